// File: doc/BRIEF.md
# SDRAM Burst Command Sequencer

This block turns a four-beat host burst request into the command stream of one SDRAM chip-select. A request gives a direction, a start word address split into row and column, and a byte-enable mask. The sequencer opens the row with an activate and waits the RAS-to-CAS delay. It then issues one READ or WRITE command per beat, raising the column address by one on each beat. At the end it closes the row with a precharge-all. The device's own burst logic is not used, so its mode register must be programmed for single accesses (burst length one) with CAS latency 2.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle and the precharge-to-activate time has run out. A request that is presented early is held by the host until then.

Write beats form a stream. A WRITE command goes out only in a cycle where `wd_valid` is high, and `wd_ready` marks the beat as taken. If write data is withheld, NOP cycles are inserted between the beats. Read beats cannot be stalled. Each captured word comes out as a one-cycle `rd_valid` pulse, and the host must take it in that cycle.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the command lines carry NOP, `req_ready` is high, and `rd_valid`, `wd_ready`, `done`, `sd_dq_oe` and `sd_dqm` are all low.
- R2: The command {cs_n, ras_n, cas_n, we_n} is encoded as follows: activate 0011, read 0101, write 0100, precharge-all 0010, NOP 0111. Precharge-all drives address bit 10 high and all other address bits low.
- R3: An activate carrying row `req_addr[19:8]` is issued in the cycle after a request is accepted. The first column command follows exactly T_RCD (2) cycles after the activate, and NOP fills the gap.
- R4: Each of the four beats gets its own column command. The column for beat i is `req_addr[7:0]` + i, modulo 256, driven on address bits 7:0 with bit 10 low. Read commands go out in back-to-back cycles.
- R5: The word on `sd_dq_in` that is sampled CAS_LAT (2) cycles after a READ is returned on `rd_data`, with `rd_valid` high for one cycle, CAS_LAT+1 cycles after that READ. Beats are returned in order.
- R6: A WRITE command goes out only in a cycle where `wd_valid` is high. In that same cycle `wd_ready` is high, `sd_dq_out` equals `wd_data`, `sd_dq_oe` is high and `sd_dqm` equals the inverted request byte-enables. A column-phase cycle where `wd_valid` is low carries a NOP.
- R7: In any cycle without a WRITE command, `sd_dqm` is zero and `sd_dq_oe` is low.
- R8: Precharge-all is issued one cycle after the last WRITE of a write burst, and CAS_LAT+1 cycles after the last READ of a read burst.
- R9: `done` pulses for exactly one cycle, in the cycle right after precharge-all.
- R10: `req_ready` is low from acceptance until the cycle after precharge-all. No activate is issued earlier than T_RP (2) cycles after a precharge-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 20 | Start word address: row in bits 19:8, column in bits 7:0 |
| req_be | input | 4 | Byte enables used for every write beat |
| wd_valid | input | 1 | Write data word offered |
| wd_ready | output | 1 | Write beat issued this cycle |
| wd_data | input | 32 | Write data word |
| rd_valid | output | 1 | Read beat returned this cycle |
| rd_data | output | 32 | Read data word |
| done | output | 1 | One-cycle pulse after the burst's precharge |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Multiplexed row/column address |
| sd_dqm | output | 4 | Data mask, 1 = byte masked |
| sd_dq_out | output | 32 | Write data to the device |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_in | input | 32 | Read data from the device |

## Verification
Two pairs of events share a cycle. In a read burst, the last data word is captured in the same cycle that precharge-all goes out. After any burst, the `done` pulse coincides with the first cycle in which a new request can be accepted. The bench starts the next request in the very cycle it expects `done`. It checks that `req_ready` is already high there and that the following activate lands exactly T_RP cycles after the precharge. In read bursts it checks, in the precharge cycle itself, both the command and the fourth `rd_valid` with its data.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACTV  = 4'b0011,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_PALL  = 4'b0010,
    CMD_NOP   = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_COL, ST_CLW, ST_PRE
  } seq_state_e;

  localparam int AP_BIT = 10;
endpackage

// File: rtl/sdram_addr_gen.sv
module sdram_addr_gen
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] base_row,
  input  logic [COL_W-1:0] base_col,
  input  logic             step,
  input  sd_cmd_e          cmd,
  output logic [ROW_W-1:0] sd_addr
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load) begin
      row_q <= base_row;
      col_q <= base_col;
    end else if (step) begin
      col_q <= col_q + 1'b1;
    end
  end

  always_comb begin
    sd_addr = '0;
    case (cmd)
      CMD_ACTV:            sd_addr = row_q;
      CMD_READ, CMD_WRITE: sd_addr = ROW_W'(col_q);
      CMD_PALL:            sd_addr[AP_BIT] = 1'b1;
      default:             sd_addr = '0;
    endcase
  end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W = 32,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [LAT-1:0] pipe_q;

  generate
    if (LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= issue;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[LAT-2:0], issue};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pipe_q[LAT-1];
      if (pipe_q[LAT-1]) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_rp_timer.sv
module sdram_rp_timer #(
  parameter int T_RP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic clear
);
  localparam int CW = (T_RP > 2) ? $clog2(T_RP) : 1;
  localparam logic [CW-1:0] LOAD = CW'(T_RP - 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign clear = (cnt_q == '0);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int BEATS   = 4,
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_RP    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0]      req_be,
  input  logic                     wd_valid,
  output logic                     wd_ready,
  input  logic [DATA_W-1:0]        wd_data,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     done,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [ROW_W-1:0]         sd_addr,
  output logic [DATA_W/8-1:0]      sd_dqm,
  output logic [DATA_W-1:0]        sd_dq_out,
  output logic                     sd_dq_oe,
  input  logic [DATA_W-1:0]        sd_dq_in
);
  localparam int NB    = DATA_W / 8;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CNT_W = $clog2(T_RCD + CAS_LAT + 1);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 2);
  localparam logic [CNT_W-1:0] CL_LD  = CNT_W'(CAS_LAT - 1);
  localparam logic [BW-1:0]    LAST_B = BW'(BEATS - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BW-1:0]     beat_q;
  logic              is_wr_q;
  logic [NB-1:0]     be_q;
  logic              rp_clear;
  logic              accept;
  logic              col_go;
  sd_cmd_e           cmd;

  assign req_ready = (state_q == ST_IDLE) && rp_clear;
  assign accept    = req_valid && req_ready;
  assign col_go    = (state_q == ST_COL) && (!is_wr_q || wd_valid);

  always_comb begin
    case (state_q)
      ST_ACT:  cmd = CMD_ACTV;
      ST_COL:  cmd = col_go ? (is_wr_q ? CMD_WRITE : CMD_READ) : CMD_NOP;
      ST_PRE:  cmd = CMD_PALL;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  assign wd_ready  = col_go && is_wr_q;
  assign sd_dq_oe  = wd_ready;
  assign sd_dq_out = wd_ready ? wd_data : '0;
  assign sd_dqm    = wd_ready ? ~be_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      is_wr_q <= 1'b0;
      be_q    <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state_q == ST_PRE);
      case (state_q)
        ST_IDLE: if (accept) begin
          is_wr_q <= req_write;
          be_q    <= req_be;
          beat_q  <= '0;
          state_q <= ST_ACT;
        end
        ST_ACT: begin
          cnt_q   <= RCD_LD;
          state_q <= ST_RCD;
        end
        ST_RCD: begin
          if (cnt_q == '0) state_q <= ST_COL;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_COL: if (col_go) begin
          if (beat_q == LAST_B) begin
            if (is_wr_q) state_q <= ST_PRE;
            else begin
              state_q <= ST_CLW;
              cnt_q   <= CL_LD;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_CLW: begin
          if (cnt_q == '0) state_q <= ST_PRE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sdram_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .base_row (req_addr[ROW_W+COL_W-1:COL_W]),
    .base_col (req_addr[COL_W-1:0]),
    .step     (col_go),
    .cmd      (cmd),
    .sd_addr  (sd_addr)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .LAT(CAS_LAT)) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (col_go && !is_wr_q),
    .dq_in    (sd_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  sdram_rp_timer #(.T_RP(T_RP)) u_rp (
    .clk   (clk),
    .rst_n (rst_n),
    .start (state_q == ST_PRE),
    .clear (rp_clear)
  );
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int NB     = 4,
  parameter int T_RP   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic [NB-1:0]    sd_dqm,
  input logic             sd_dq_oe,
  input logic             wd_valid,
  input logic             wd_ready,
  input logic             rd_valid,
  input logic             done
);
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  logic [7:0] since_pall;
  logic [3:0] rd_open;
  logic       row_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pall <= 8'hFF;
      rd_open    <= '0;
      row_open   <= 1'b0;
    end else begin
      if (cmd == CMD_PALL)         since_pall <= 8'd1;
      else if (since_pall != 8'hFF) since_pall <= since_pall + 8'd1;
      rd_open <= rd_open + 4'((cmd == CMD_READ)) - 4'(rd_valid);
      if (cmd == CMD_ACTV)      row_open <= 1'b1;
      else if (cmd == CMD_PALL) row_open <= 1'b0;
    end
  end

  a_r2_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PALL) |-> sd_addr[AP_BIT]);

  a_r3_col_in_open_row: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ || cmd == CMD_WRITE) |-> row_open);

  a_r5_rd_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_open != 4'd0));

  a_r6_wr_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> (cmd == CMD_WRITE && wd_valid && sd_dq_oe));

  a_r7_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_WRITE) |-> (sd_dqm == '0 && !sd_dq_oe));

  a_r9_done_follows_pall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cmd) == CMD_PALL));

  a_r10_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACTV) |-> (since_pall >= 8'(T_RP)));
endmodule

bind sdram_burst_seq sdram_seq_chk #(.ROW_W(ROW_W), .NB(DATA_W/8), .T_RP(T_RP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_addr  (sd_addr),
  .sd_dqm   (sd_dqm),
  .sd_dq_oe (sd_dq_oe),
  .wd_valid (wd_valid),
  .wd_ready (wd_ready),
  .rd_valid (rd_valid),
  .done     (done)
);

// File: tb/tb_sdram_burst_seq.sv
module tb_sdram_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BEATS = 4;
  localparam int T_RCD = 2;
  localparam int CL    = 2;
  localparam int T_RP  = 2;

  localparam logic [3:0] C_ACTV = 4'b0011;
  localparam logic [3:0] C_READ = 4'b0101;
  localparam logic [3:0] C_WR   = 4'b0100;
  localparam logic [3:0] C_PALL = 4'b0010;
  localparam logic [3:0] C_NOP  = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [31:0] wd_data = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        done;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_addr;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_dq_out;
  logic        sd_dq_oe;
  logic [31:0] sd_dq_in = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_pall = -1;
  logic [11:0] cur_row = '0;
  logic [7:0]  cur_seed = '0;

  sdram_burst_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] pat(input logic [11:0] r, input logic [7:0] s,
                                      input logic [7:0] c);
    return {r, 4'h0, s, c};
  endfunction

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  // device model: data for a READ appears CL cycles later
  logic       d1v = 1'b0, d2v = 1'b0;
  logic [7:0] d1c = '0, d2c = '0;
  always @(negedge clk) begin
    sd_dq_in <= d2v ? pat(cur_row, cur_seed, d2c) : 32'hBAD0_BAD0;
    d2v <= d1v;
    d2c <= d1c;
    d1v <= (cmd_now() == C_READ);
    d1c <= sd_addr[7:0];
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_txn(input bit w, input logic [19:0] addr, input logic [3:0] be,
                         input int stall_pct, input int gap);
    int i;
    int kl;
    int pk;
    int nrd;
    int rdk[BEATS];
    bit fin;
    logic [7:0] col0;
    logic [3:0] c;
    logic       wv;
    bit         expv;
    int         ej;
    repeat (gap) @(negedge clk);
    cur_row  = addr[19:8];
    cur_seed = 8'($urandom);
    col0     = addr[7:0];
    req_valid = 1'b1;
    req_write = w;
    req_addr  = addr;
    req_be    = be;
    #1;
    chk("R10 ready at request", {31'b0, req_ready}, 32'd1);
    i = 0; kl = 0; pk = 1000; nrd = 0; fin = 0;
    for (int k = 1; k < 80 && !fin; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      wv = 1'b0;
      if (w && k > T_RCD && i < BEATS) wv = ($urandom % 100) >= stall_pct;
      wd_valid = wv;
      wd_data  = pat(cur_row, cur_seed, 8'(col0 + 8'(i)));
      #1;
      c = cmd_now();
      if (k <= pk) chk("R10 ready low while busy", {31'b0, req_ready}, 32'd0);
      if (k <= pk) chk("R9 done low during burst", {31'b0, done}, 32'd0);
      if (c != C_WR) chk("R7 mask/oe idle", {27'b0, sd_dq_oe, sd_dqm}, 32'd0);
      // read data return
      expv = 1'b0; ej = 0;
      for (int j = 0; j < BEATS; j++)
        if (!w && j < i && rdk[j] + CL + 1 == k) begin expv = 1'b1; ej = j; end
      chk("R5 rd_valid timing", {31'b0, rd_valid}, {31'b0, expv});
      if (expv) begin
        chk("R5 rd_data", rd_data, pat(cur_row, cur_seed, 8'(col0 + 8'(ej))));
        nrd++;
      end
      if (k == 1) begin
        chk("R3 ACTV code", {28'b0, c}, {28'b0, C_ACTV});
        chk("R3 row address", {20'b0, sd_addr}, {20'b0, addr[19:8]});
        if (last_pall >= 0) chk("R10 PALL-to-ACTV gap", (cyc - last_pall) >= T_RP, 32'd1);
      end else if (k <= T_RCD) begin
        chk("R3 NOP in RCD gap", {28'b0, c}, {28'b0, C_NOP});
      end else if (i < BEATS) begin
        if (w) begin
          if (wv) begin
            chk("R6 WRITE code", {28'b0, c}, {28'b0, C_WR});
            chk("R4 write column", {20'b0, sd_addr}, {24'b0, 8'(col0 + 8'(i))});
            chk("R6 dq_out", sd_dq_out, wd_data);
            chk("R6 oe/ready/dqm", {26'b0, sd_dq_oe, wd_ready, sd_dqm},
                {26'b0, 1'b1, 1'b1, ~be});
            i++;
            if (i == BEATS) begin kl = k; pk = k + 1; end
          end else begin
            chk("R6 stalled beat NOP", {27'b0, wd_ready, c}, {27'b0, 1'b0, C_NOP});
          end
        end else begin
          chk("R4 READ code", {28'b0, c}, {28'b0, C_READ});
          chk("R4 read column", {20'b0, sd_addr}, {24'b0, 8'(col0 + 8'(i))});
          rdk[i] = k;
          i++;
          if (i == BEATS) begin kl = k; pk = k + CL + 1; end
        end
      end else if (k < pk) begin
        chk("R8 NOP before PALL", {28'b0, c}, {28'b0, C_NOP});
      end else if (k == pk) begin
        chk("R8 PALL code", {28'b0, c}, {28'b0, C_PALL});
        chk("R2 PALL address", {20'b0, sd_addr}, 32'h400);
        last_pall = cyc;
      end else begin
        chk("R9 done pulse", {31'b0, done}, 32'd1);
        if (!w) chk("R5 beats returned", nrd, BEATS);
        fin = 1;
      end
    end
    wd_valid = 1'b0;
    if (!fin) chk("R8 burst completion", 32'd0, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd5234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 NOP after reset", {28'b0, cmd_now()}, {28'b0, C_NOP});
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1 outputs low", {26'b0, rd_valid, wd_ready, done, sd_dq_oe, |sd_dqm, 1'b0}, 32'd0);
    // directed: column wrap on read, early-next request on done cycle
    run_txn(1'b0, {12'h123, 8'hFE}, 4'hF, 0, 0);
    run_txn(1'b1, {12'hABC, 8'hFD}, 4'b0101, 0, 0);
    run_txn(1'b1, {12'h00F, 8'h10}, 4'b1110, 60, 0);
    run_txn(1'b0, {12'hFFF, 8'hFF}, 4'h0, 0, 2);
    run_txn(1'b1, {12'h555, 8'h00}, 4'h0, 0, 1);
    for (int n = 0; n < 40; n++)
      run_txn(1'($urandom), 20'($urandom), 4'($urandom), int'($urandom % 50),
              int'($urandom % 3));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule